// File: doc/BRIEF.md
# Serial EEPROM Write Guard and Page Programmer

This block is the write side of a serial EEPROM model. A serial front end decodes the command byte, address and data bytes, then hands them over as single-cycle strobes. The block decides whether a write may proceed. That decision uses three things: a write-enable latch, the active-low write-protect pin, and a two-bit block-protection field. An accepted page write collects up to one page of bytes in a local buffer. When chip select is released cleanly, the buffer is committed to the storage array through a simple write port.

The commit runs inside a timed busy interval of `TWC_CYCLES` system clocks. During that interval only status reads have any meaning. The block also produces the status byte that a status read returns. That byte carries busy, the write-enable latch and the two protection bits.

Top module: `eewp_engine`

## Requirements
- R1: After reset the status byte is 0x00 and the array write port stays idle.
- R2: A set-enable strobe sets the write-enable latch only while `wp_n` is high. A clear-enable strobe clears the latch at any level of `wp_n`.
- R3: A page-write or status-write command is ignored unless the latch is set and `wp_n` is high when the command strobe arrives. An ignored command leaves the array and the status byte unchanged.
- R4: If `wp_n` goes low while a command is still collecting bytes, the command is abandoned. The array is untouched and the latch keeps its value. Once a busy interval has started, `wp_n` has no effect on it.
- R5: Each data byte goes to the slot given by the low 3 address bits. That slot then increments modulo 8 while the upper address bits stay fixed. More than 8 bytes therefore overwrite earlier slots of the same page, and only the last byte written to each slot is committed.
- R6: Programming starts only on `cs_rise` with `cs_partial` low, after at least one full byte. A rise with `cs_partial` high, or with no byte received, abandons the command and leaves the array and latch unchanged.
- R7: Protection field bp = status[3:2]. The value 0 protects nothing, 1 protects addresses whose two top bits are 11, 2 protects addresses whose top bit is 1, and 3 protects everything. Bytes aimed at protected addresses are discarded, and the other bytes of the page are still written.
- R8: Status bit 0 is 1 for exactly `TWC_CYCLES` clocks, starting the cycle after the accepted `cs_rise`. While busy, all command strobes are ignored.
- R9: The write-enable latch clears at the end of every busy interval.
- R10: The status byte layout is bit0 busy, bit1 latch, bit2 bp[0], bit3 bp[1], and bits 7..4 always read 0. A status write takes only data bits 3:2, which become bp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_n | input | 1 | Write-protect pin, low blocks writes |
| cmd_wren | input | 1 | Set-enable command strobe |
| cmd_wrdi | input | 1 | Clear-enable command strobe |
| cmd_wrsr | input | 1 | Status-write command strobe |
| cmd_write | input | 1 | Page-write command strobe, with address |
| cmd_addr | input | ADDR_W | Start byte address of a page write |
| byte_valid | input | 1 | A full data byte has arrived |
| byte_data | input | 8 | The data byte |
| cs_rise | input | 1 | Chip select has just gone high |
| cs_partial | input | 1 | Qualifies cs_rise: a byte was incomplete |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| status | output | 8 | Status byte for a status read |

## Verification
The bench builds the block with a 9-bit address, 8-byte pages and `TWC_CYCLES` = 20. With a 20-cycle busy interval, a run covers hundreds of complete write cycles, and the exact first and last busy cycle can be checked. An 8-byte page within a 512-byte array puts all four protection ranges on page boundaries. That lets random addresses hit both protected and open pages under every bp value, and random page lengths of 0 to 12 reach the wrap-around and overwrite case.

// File: rtl/eewp_pkg.sv
package eewp_pkg;
    typedef enum logic [1:0] {
        EW_IDLE,
        EW_PAGE,
        EW_SREG,
        EW_PROG
    } ew_state_e;
endpackage

// File: rtl/eewp_zone_guard.sv
module eewp_zone_guard #(
    parameter int ADDR_W = 9
) (
    input  logic [1:0]        bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              locked_o
);
    always_comb begin
        case (bp_i)
            2'd0:    locked_o = 1'b0;
            2'd1:    locked_o = &addr_i[ADDR_W-1 -: 2];
            2'd2:    locked_o = addr_i[ADDR_W-1];
            default: locked_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/eewp_page_buf.sv
module eewp_page_buf #(
    parameter int PAGE_BYTES = 8,
    parameter int DATA_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          open_i,
    input  logic [$clog2(PAGE_BYTES)-1:0] open_slot_i,
    input  logic                          push_i,
    input  logic [DATA_W-1:0]             push_data_i,
    input  logic [$clog2(PAGE_BYTES)-1:0] rd_idx_i,
    output logic [DATA_W-1:0]             rd_data_o,
    output logic                          rd_valid_o,
    output logic                          filled_o
);
    localparam int PW = $clog2(PAGE_BYTES);

    typedef struct packed {
        logic [PAGE_BYTES-1:0][DATA_W-1:0] data;
        logic [PAGE_BYTES-1:0]             valid;
        logic [PW-1:0]                     ptr;
    } pbuf_s;

    pbuf_s buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (open_i) begin
            buf_d.valid = '0;
            buf_d.ptr   = open_slot_i;
        end else if (push_i) begin
            buf_d.data[buf_q.ptr]  = push_data_i;
            buf_d.valid[buf_q.ptr] = 1'b1;
            buf_d.ptr              = buf_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign rd_data_o  = buf_q.data[rd_idx_i];
    assign rd_valid_o = buf_q.valid[rd_idx_i];
    assign filled_o   = |buf_q.valid;

    // R5: a stored byte always leaves the buffer non-empty
    assert_push_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !open_i) |=> filled_o);
    // R5: the fill pointer advances by exactly one slot per byte
    assert_ptr_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !open_i) |=> (buf_q.ptr == PW'($past(buf_q.ptr) + 1'b1)));
endmodule

// File: rtl/eewp_engine.sv
module eewp_engine #(
    parameter int ADDR_W     = 9,
    parameter int PAGE_BYTES = 8,
    parameter int TWC_CYCLES = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              cs_rise,
    input  logic              cs_partial,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic [7:0]        status
);
    import eewp_pkg::*;

    localparam int PW    = $clog2(PAGE_BYTES);
    localparam int UPW   = ADDR_W - PW;
    localparam int CNT_W = $clog2(TWC_CYCLES + 1);

    typedef struct packed {
        ew_state_e        st;
        logic             wel;
        logic [1:0]       bp;
        logic [UPW-1:0]   page;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       sreg_new;
        logic             sreg_got;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic          buf_open, buf_push, buf_filled, slot_valid, locked;
    logic [PW-1:0] commit_idx;
    logic          busy, in_window;

    always_comb begin
        ctl_d    = ctl_q;
        buf_open = 1'b0;
        buf_push = 1'b0;
        case (ctl_q.st)
            EW_IDLE: begin
                if (cmd_wrdi) begin
                    ctl_d.wel = 1'b0;
                end else if (cmd_wren) begin
                    if (wp_n) ctl_d.wel = 1'b1;
                end else if (cmd_write && ctl_q.wel && wp_n) begin
                    ctl_d.st   = EW_PAGE;
                    ctl_d.page = cmd_addr[ADDR_W-1:PW];
                    buf_open   = 1'b1;
                end else if (cmd_wrsr && ctl_q.wel && wp_n) begin
                    ctl_d.st       = EW_SREG;
                    ctl_d.sreg_got = 1'b0;
                    buf_open       = 1'b1;
                end
            end
            EW_PAGE: begin
                if (!wp_n) begin
                    ctl_d.st = EW_IDLE;
                end else if (cs_rise) begin
                    ctl_d.cnt = '0;
                    ctl_d.st  = (!cs_partial && buf_filled) ? EW_PROG : EW_IDLE;
                end else if (byte_valid) begin
                    buf_push = 1'b1;
                end
            end
            EW_SREG: begin
                if (!wp_n) begin
                    ctl_d.st = EW_IDLE;
                end else if (cs_rise) begin
                    ctl_d.cnt = '0;
                    if (!cs_partial && ctl_q.sreg_got) begin
                        ctl_d.st = EW_PROG;
                        ctl_d.bp = ctl_q.sreg_new;
                    end else begin
                        ctl_d.st = EW_IDLE;
                    end
                end else if (byte_valid) begin
                    ctl_d.sreg_new = byte_data[3:2];
                    ctl_d.sreg_got = 1'b1;
                end
            end
            default: begin
                ctl_d.cnt = ctl_q.cnt + 1'b1;
                if (ctl_q.cnt == CNT_W'(TWC_CYCLES - 1)) begin
                    ctl_d.st  = EW_IDLE;
                    ctl_d.wel = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= EW_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    eewp_page_buf #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (8)
    ) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_i      (buf_open),
        .open_slot_i (cmd_addr[PW-1:0]),
        .push_i      (buf_push),
        .push_data_i (byte_data),
        .rd_idx_i    (commit_idx),
        .rd_data_o   (mem_wdata),
        .rd_valid_o  (slot_valid),
        .filled_o    (buf_filled)
    );

    eewp_zone_guard #(
        .ADDR_W (ADDR_W)
    ) u_guard (
        .bp_i     (ctl_q.bp),
        .addr_i   (mem_addr),
        .locked_o (locked)
    );

    assign busy       = (ctl_q.st == EW_PROG);
    assign commit_idx = ctl_q.cnt[PW-1:0];
    assign in_window  = busy && (ctl_q.cnt < CNT_W'(PAGE_BYTES));
    assign mem_addr   = {ctl_q.page, commit_idx};
    assign mem_we     = in_window && slot_valid && !locked;
    assign status     = {4'b0000, ctl_q.bp, ctl_q.wel, busy};

    // R1: nothing is written in the first cycle out of reset
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !mem_we);
    // R2: with wp_n low a cleared latch stays cleared
    assert_wren_needs_wp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[1] && !wp_n) |=> !status[1]);
    // R2: clear-enable outside a busy interval empties the latch
    assert_wrdi_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrdi && !status[0] && ctl_q.st == EW_IDLE) |=> !status[1]);
    // R6: a busy interval opens only on a clean chip-select rise
    assert_busy_on_clean_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(cs_rise && !cs_partial));
    // R9: the latch is empty when a busy interval closes
    assert_wel_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> !status[1]);
    // R8: protection bits cannot move during a busy interval
    assert_bp_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |=> $stable(status[3:2]));
    // R7: full protection means no array write at all
    assert_full_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3:2] == 2'b11) |-> !mem_we);
    // R10: the high nibble of status is always zero
    assert_high_nibble_R10: assert property (@(posedge clk) disable iff (!rst_n)
        status[7:4] == 4'h0);
endmodule

// File: tb/sim_eewp_engine.sv
module sim_eewp_engine;
    localparam int AW  = 9;
    localparam int PB  = 8;
    localparam int TWC = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wp_n = 1'b1, cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_wrsr = 1'b0, cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic cs_rise = 1'b0, cs_partial = 1'b0;
    logic mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata, status;

    always #10 clk = ~clk;

    eewp_engine #(.ADDR_W(AW), .PAGE_BYTES(PB), .TWC_CYCLES(TWC)) u0 (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
        .cmd_wrsr(cmd_wrsr), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .cs_rise(cs_rise),
        .cs_partial(cs_partial), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .status(status));

    logic [7:0] exp_mem [1<<AW];
    logic [7:0] obs_mem [1<<AW];
    logic [7:0] wr_bytes [16];
    logic       wel_m = 1'b0;
    logic [1:0] bp_m = 2'b00;
    int checks = 0, errors = 0, cyc = 0;

    initial begin
        for (int i = 0; i < (1<<AW); i++) begin
            exp_mem[i] = 8'h00;
            obs_mem[i] = 8'h00;
        end
    end

    always @(posedge clk) if (mem_we) obs_mem[mem_addr] <= mem_wdata;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<=150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_mem(input string tag);
        int bad = 0;
        for (int i = 0; i < (1<<AW); i++) if (obs_mem[i] !== exp_mem[i]) bad++;
        chk(bad, 0, {tag, " array mismatches"});
    endtask

    task automatic chk_status(input string tag);
        chk({24'h0, status}, {24'h0, 4'h0, bp_m, wel_m, 1'b0}, {tag, " status"});
    endtask

    function automatic logic prot(input logic [1:0] bp, input logic [AW-1:0] a);
        case (bp)
            2'd0:    return 1'b0;
            2'd1:    return a[AW-1:AW-2] == 2'b11;
            2'd2:    return a[AW-1];
            default: return 1'b1;
        endcase
    endfunction

    // Expected effect of a page-write frame (R3..R7, R9)
    task automatic model_write(input logic [AW-1:0] a, input int n, input int mode,
                               input logic wp_cmd, output logic commit);
        logic [7:0] pg [PB];
        logic [PB-1:0] v = '0;
        logic [2:0] s = a[2:0];
        commit = wel_m && wp_cmd && (mode == 0) && (n > 0);
        for (int i = 0; i < n; i++) begin
            pg[s] = wr_bytes[i];
            v[s]  = 1'b1;
            s     = s + 3'd1;
        end
        if (commit) begin
            for (int k = 0; k < PB; k++) begin
                logic [AW-1:0] t = {a[AW-1:3], 3'(k)};
                if (v[k] && !prot(bp_m, t)) exp_mem[t] = pg[k];
            end
            wel_m = 1'b0;
        end
    endtask

    task automatic frame_write(input logic [AW-1:0] a, input int n, input int mode, input logic wp_cmd);
        wp_n = wp_cmd; cmd_write = 1'b1; cmd_addr = a;
        @(negedge clk);
        cmd_write = 1'b0; wp_n = 1'b1;
        for (int i = 0; i < n; i++) begin
            if (mode == 2 && i == n / 2) begin
                wp_n = 1'b0; @(negedge clk); wp_n = 1'b1;
            end
            byte_valid = 1'b1; byte_data = wr_bytes[i];
            @(negedge clk);
        end
        byte_valid = 1'b0;
        if (mode == 2 && n == 0) begin
            wp_n = 1'b0; @(negedge clk); wp_n = 1'b1;
        end
        cs_rise = 1'b1; cs_partial = (mode == 1);
        @(negedge clk);
        cs_rise = 1'b0; cs_partial = 1'b0;
    endtask

    task automatic frame_wrsr(input logic [7:0] d, input logic partial);
        cmd_wrsr = 1'b1;
        @(negedge clk);
        cmd_wrsr = 1'b0; byte_valid = 1'b1; byte_data = d;
        @(negedge clk);
        byte_valid = 1'b0; cs_rise = 1'b1; cs_partial = partial;
        @(negedge clk);
        cs_rise = 1'b0; cs_partial = 1'b0;
    endtask

    // Called one cycle after the cs_rise cycle (R8 timing)
    task automatic finish_cycle(input logic commit, input string tag);
        chk(status[0], commit, {tag, " R8 busy first cycle"});
        if (commit) begin
            repeat (TWC - 1) @(negedge clk);
            chk(status[0], 1'b1, {tag, " R8 busy last cycle"});
            @(negedge clk);
            chk(status[0], 1'b0, {tag, " R8 busy released"});
        end
        chk_status({tag, " R9/R10"});
        chk_mem(tag);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input int n, input int mode,
                            input logic wp_cmd, input string tag);
        logic c;
        model_write(a, n, mode, wp_cmd, c);
        frame_write(a, n, mode, wp_cmd);
        finish_cycle(c, tag);
    endtask

    task automatic do_wrsr(input logic [7:0] d, input logic partial, input logic wp_cmd,
                           input string tag);
        logic c = wel_m && wp_cmd && !partial;
        wp_n = wp_cmd;
        frame_wrsr(d, partial);
        wp_n = 1'b1;
        if (c) begin
            bp_m = d[3:2];
            wel_m = 1'b0;
        end
        finish_cycle(c, tag);
    endtask

    task automatic do_en(input logic set, input logic wp, input string tag);
        wp_n = wp;
        if (set) cmd_wren = 1'b1; else cmd_wrdi = 1'b1;
        @(negedge clk);
        cmd_wren = 1'b0; cmd_wrdi = 1'b0; wp_n = 1'b1;
        if (!set) wel_m = 1'b0;
        else if (wp) wel_m = 1'b1;
        chk_status(tag);
    endtask

    task automatic fill_bytes();
        for (int i = 0; i < 16; i++) wr_bytes[i] = 8'($urandom);
    endtask

    initial begin
        logic c;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_status("R1 reset");
        chk_mem("R1 reset");

        fill_bytes();
        do_write(9'h040, 3, 0, 1'b1, "R3 write without enable");
        do_en(1'b1, 1'b0, "R2 wren with wp low");
        do_en(1'b1, 1'b1, "R2 wren with wp high");
        do_en(1'b0, 1'b0, "R2 wrdi with wp low");
        do_en(1'b1, 1'b1, "R2 wren again");
        do_write(9'h050, 3, 0, 1'b0, "R3 write with wp low at command");

        fill_bytes();
        do_write(9'h0F6, 10, 0, 1'b1, "R5 page wrap overwrite");
        do_en(1'b1, 1'b1, "R2 wren");
        do_wrsr(8'hFF, 1'b0, 1'b1, "R10 wrsr only bp bits");
        do_en(1'b1, 1'b1, "R2 wren");
        do_wrsr(8'h04, 1'b0, 1'b1, "R7 bp=1");
        do_en(1'b1, 1'b1, "R2 wren");
        fill_bytes();
        do_write(9'h1F8, 8, 0, 1'b1, "R7 top quarter locked");
        do_en(1'b1, 1'b1, "R2 wren");
        do_write(9'h100, 4, 0, 1'b1, "R7 third quarter open");
        do_en(1'b1, 1'b1, "R2 wren");
        do_wrsr(8'h08, 1'b0, 1'b1, "R7 bp=2");
        do_en(1'b1, 1'b1, "R2 wren");
        fill_bytes();
        do_write(9'h108, 4, 0, 1'b1, "R7 upper half locked");

        do_en(1'b1, 1'b1, "R2 wren");
        do_write(9'h020, 5, 1, 1'b1, "R6 partial byte abort");
        do_write(9'h020, 0, 0, 1'b1, "R6 no data byte");
        do_write(9'h020, 5, 2, 1'b1, "R4 wp drop abandons");

        // R8/R4: commands and wp during a busy interval
        fill_bytes();
        model_write(9'h028, 2, 0, 1'b1, c);
        frame_write(9'h028, 2, 0, 1'b1);
        wp_n = 1'b0;
        frame_wrsr(8'h0C, 1'b0);
        wp_n = 1'b1;
        repeat (TWC + 4) @(negedge clk);
        chk_status("R8 wrsr ignored while busy, R4 wp ignored while busy");
        chk_mem("R4 busy cycle completes with wp low");

        for (int it = 0; it < 250; it++) begin
            int op = $urandom % 7;
            logic wpc = ($urandom % 5) != 0;
            fill_bytes();
            case (op)
                0, 1: do_en(1'b1, wpc, "R2 random wren");
                2:    do_en(1'b0, wpc, "R2 random wrdi");
                3, 4, 5: begin
                    int md = $urandom % 5;
                    do_write(AW'($urandom), $urandom % 13, (md > 2) ? md - 2 : 0, wpc,
                             "R5 R7 random write");
                end
                default: do_wrsr(8'($urandom), ($urandom % 5) == 0, wpc, "R10 random wrsr");
            endcase
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule